// File: doc/BRIEF.md
# SD Command and Response Engine

This block drives the command line of an SD/MMC card. Software writes a 32-bit argument, then writes a send word holding the command byte and the response options. The engine shifts out the command byte, the argument, a CRC7 and a stop bit on the command line. It then waits for the card's response start bit and captures a response whose length in bits is set by software. It can check the response CRC7 in one of two variants and can hold completion until data line 0 leaves busy. When the exchange ends it raises a done flag, which can drive an interrupt.

The card clock comes from the system clock through a programmable divider. A small word-addressed register port holds the argument, send, configuration, status, control and multiplex registers. A captured response is read back as 32-bit words through the argument address, using a readback index that steps forward on each read. A watchdog ends a command with a timeout flag if the card never starts a response.

Top module: `sd_cmd_engine`

## Requirements
- R1: After reset, the configuration register (word address 2) reads `0x400271F4`: divider field [9:0] = 500, argument-bit field [17:12] = 39 and watchdog field [31:24] = 64. Status (address 3) reads 0, `cmd_o` is 1 and `sd_clk` is 0.
- R2: `sd_clk` toggles every DIV+1 system clocks, so its period is 2·(DIV+1) system clocks, where DIV is the divider field.
- R3: A command frame is driven MSB first, one bit per `sd_clk` falling edge. It carries the 8-bit command byte from send bits [7:0], the 32-bit argument (address 0), a CRC7 and a 1 stop bit, 9 + argument-bit-field bits in all (48 by default). The CRC7 uses x^7+x^3+1 with zero initial value over the 40 byte and argument bits. `cmd_o` is 1 whenever no command is active.
- R4: With a response length N in send bits [15:8] that is not zero, the engine samples `cmd_i` on `sd_clk` rising edges. It waits for a 0 start bit, then captures N+1 further bits and stores the most recent 128 in capture order, the last bit at position 0. With N = 0 the command completes after the frame.
- R5: The CRC7 check covers the start bit and captured bits 0..N−7 and is compared with the last 7 captured bits. Status bit 5 is set when they match and send bit 16 is 0. With send bit 16 set, status bit 5 stays 0.
- R6: With send bit 18 set, the check covers only captured bits 7..N−7 (the 120 content bits of a 133-bit response).
- R7: With send bit 19 set, completion waits until `dat0_i` is sampled 1 on an `sd_clk` rising edge after the frame and any response.
- R8: Completion sets status bit 9. Writing 1 to status bits 5, 9 or 10 clears them. `irq` equals status bit 9 AND control bit 4.
- R9: When multiplex bit 8 is set, a read of address 0 returns captured word [idx mod 4]·32+31 : [idx mod 4]·32, word 0 being the last 32 captured bits, where idx is multiplex field [15:12]. Each such read increments idx. With bit 8 clear, address 0 returns the argument.
- R10: If no start bit is seen within watchdog-field+1 rising edges after the frame, status bits 10 and 9 are set and bit 5 stays 0.
- R11: A write to the send register while a command is active (status bit 0) is ignored: the frame in flight and the send register readback are unchanged.
- R12: Writing control (address 4) with bit 15 set returns the engine to idle at once, clears status and drives `cmd_o` to 1. Bit 15 always reads 0.
- R13: Multiplex bits [1:0] are presented on `port_sel`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (advances readback index) |
| reg_addr | input | 3 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational on address |
| sd_clk | output | 1 | Card clock |
| cmd_o | output | 1 | Command line drive |
| cmd_i | input | 1 | Command line sample |
| dat0_i | input | 1 | Data line 0 sample for busy detection |
| port_sel | output | 2 | Port select field |
| irq | output | 1 | Command-done interrupt |

## Verification
Random opcodes and arguments are mixed with short responses in the plain CRC variant and long responses in the content-only variant. About a quarter of the responses have a flipped CRC bit, which separates a real check from one that always passes and confirms which bits the window covers. All four readback words are compared, so the capture order and the word indexing are tested together. Directed cases cover each path that leaves the normal flow: no response, a busy hold, a silent card, a send write during a frame, and a soft reset in mid-frame. The divider period is measured at its reset value and at a small value.

// File: rtl/sd_cmd_engine.sv
`timescale 1ns/1ps
module sd_cmd_engine #(
  parameter int DIV_W     = 10,
  parameter int DIV_RST   = 500,
  parameter int ABITS_W   = 6,
  parameter int ABITS_RST = 39,
  parameter int TMO_W     = 8,
  parameter int TMO_RST   = 64
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        sd_clk,
  output logic        cmd_o,
  input  logic        cmd_i,
  input  logic        dat0_i,
  output logic [1:0]  port_sel,
  output logic        irq
);
  localparam int RX_W  = 128;
  localparam int CNT_W = 8;
  localparam int IDX_W = $clog2(RX_W / 32);

  typedef enum logic [2:0] {S_IDLE, S_TX, S_WAIT, S_RX, S_BUSY} st_t;

  logic [31:0]        arg_q;
  logic [7:0]         cmdb_q;
  logic [CNT_W-1:0]   rlen_q;
  logic               nocrc_q, lvar_q, bsy_q;
  logic [DIV_W-1:0]   div_q, dcnt;
  logic [ABITS_W-1:0] abits_q;
  logic [TMO_W-1:0]   tmo_q, wd;
  logic               ien_q, rb_en_q;
  logic [1:0]         port_q;
  logic [3:0]         rb_idx_q;
  logic               sdclk_q, cmdo_q;
  st_t                st;
  logic [39:0]        txsh;
  logic [6:0]         crc_q;
  logic [CNT_W-1:0]   bcnt;
  logic [RX_W-1:0]    rx;
  logic               ok_q, st_done, to_q;

  wire wr_arg   = reg_wr && reg_addr == 3'd0;
  wire wr_send  = reg_wr && reg_addr == 3'd1;
  wire wr_cfg   = reg_wr && reg_addr == 3'd2;
  wire wr_stat  = reg_wr && reg_addr == 3'd3;
  wire wr_ctrl  = reg_wr && reg_addr == 3'd4;
  wire wr_mux   = reg_wr && reg_addr == 3'd5;
  wire rd_arg   = reg_rd && reg_addr == 3'd0;
  wire soft_rst = wr_ctrl && reg_wdata[15];
  wire active   = st != S_IDLE;
  wire busy_st  = st == S_BUSY;
  wire wait_st  = st == S_WAIT;
  wire start    = wr_send && !active && !soft_rst;

  wire tick = dcnt >= div_q;
  wire rise = tick && !sdclk_q;
  wire fall = tick && sdclk_q;

  wire [CNT_W-1:0] tx_last = CNT_W'(abits_q) + CNT_W'(9);
  wire in_win = ({1'b0, bcnt} + 9'd7 <= {1'b0, rlen_q}) && (!lvar_q || bcnt >= CNT_W'(7));

  function automatic logic [6:0] crc_step(input logic [6:0] c, input logic b);
    logic fb;
    fb = b ^ c[6];
    return {c[5:0], 1'b0} ^ {3'b000, fb, 2'b00, fb};
  endfunction

  assign sd_clk   = sdclk_q;
  assign cmd_o    = cmdo_q;
  assign port_sel = port_q;
  assign irq      = st_done & ien_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      dcnt    <= '0;
      sdclk_q <= 1'b0;
    end else if (tick) begin
      dcnt    <= '0;
      sdclk_q <= !sdclk_q;
    end else
      dcnt <= dcnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      arg_q   <= '0;
      div_q   <= DIV_W'(DIV_RST);
      abits_q <= ABITS_W'(ABITS_RST);
      tmo_q   <= TMO_W'(TMO_RST);
      ien_q   <= 1'b0;
      port_q  <= '0;
      rb_en_q <= 1'b0;
      rb_idx_q <= '0;
    end else begin
      if (wr_arg) arg_q <= reg_wdata;
      if (wr_cfg) begin
        div_q   <= reg_wdata[DIV_W-1:0];
        abits_q <= reg_wdata[12 +: ABITS_W];
        tmo_q   <= reg_wdata[24 +: TMO_W];
      end
      if (wr_ctrl) ien_q <= reg_wdata[4];
      if (wr_mux) begin
        port_q   <= reg_wdata[1:0];
        rb_en_q  <= reg_wdata[8];
        rb_idx_q <= reg_wdata[15:12];
      end else if (rd_arg && rb_en_q)
        rb_idx_q <= rb_idx_q + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st      <= S_IDLE;
      cmdo_q  <= 1'b1;
      cmdb_q  <= '0;
      rlen_q  <= '0;
      nocrc_q <= 1'b0;
      lvar_q  <= 1'b0;
      bsy_q   <= 1'b0;
      txsh    <= '0;
      crc_q   <= '0;
      bcnt    <= '0;
      wd      <= '0;
      rx      <= '0;
      ok_q    <= 1'b0;
      st_done <= 1'b0;
      to_q    <= 1'b0;
    end else if (soft_rst) begin
      st      <= S_IDLE;
      cmdo_q  <= 1'b1;
      ok_q    <= 1'b0;
      st_done <= 1'b0;
      to_q    <= 1'b0;
    end else begin
      if (wr_stat) begin
        if (reg_wdata[5])  ok_q    <= 1'b0;
        if (reg_wdata[9])  st_done <= 1'b0;
        if (reg_wdata[10]) to_q    <= 1'b0;
      end
      case (st)
        S_IDLE: if (start) begin
          cmdb_q  <= reg_wdata[7:0];
          rlen_q  <= reg_wdata[15:8];
          nocrc_q <= reg_wdata[16];
          lvar_q  <= reg_wdata[18];
          bsy_q   <= reg_wdata[19];
          txsh    <= {reg_wdata[7:0], arg_q};
          crc_q   <= '0;
          bcnt    <= '0;
          rx      <= '0;
          ok_q    <= 1'b0;
          st_done <= 1'b0;
          to_q    <= 1'b0;
          st      <= S_TX;
        end
        S_TX: if (fall) begin
          if (bcnt == tx_last) begin
            cmdo_q <= 1'b1;
            bcnt   <= '0;
            wd     <= '0;
            crc_q  <= '0;
            if (rlen_q != '0) st <= S_WAIT;
            else if (bsy_q)   st <= S_BUSY;
            else begin
              st      <= S_IDLE;
              st_done <= 1'b1;
            end
          end else begin
            bcnt <= bcnt + 1'b1;
            if (bcnt < CNT_W'(40)) begin
              cmdo_q <= txsh[39];
              txsh   <= {txsh[38:0], 1'b0};
              crc_q  <= crc_step(crc_q, txsh[39]);
            end else if (bcnt < CNT_W'(47)) begin
              cmdo_q <= crc_q[6];
              crc_q  <= {crc_q[5:0], 1'b0};
            end else
              cmdo_q <= 1'b1;
          end
        end
        S_WAIT: if (rise) begin
          if (!cmd_i)
            st <= S_RX;
          else if (wd == tmo_q) begin
            to_q    <= 1'b1;
            st_done <= 1'b1;
            st      <= S_IDLE;
          end else
            wd <= wd + 1'b1;
        end
        S_RX: if (rise) begin
          rx   <= {rx[RX_W-2:0], cmd_i};
          bcnt <= bcnt + 1'b1;
          if (in_win) crc_q <= crc_step(crc_q, cmd_i);
          if (bcnt == rlen_q) begin
            ok_q <= !nocrc_q && ({rx[5:0], cmd_i} == crc_q);
            if (bsy_q) st <= S_BUSY;
            else begin
              st      <= S_IDLE;
              st_done <= 1'b1;
            end
          end
        end
        S_BUSY: if (rise && dat0_i) begin
          st      <= S_IDLE;
          st_done <= 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      3'd0: reg_rdata = rb_en_q ? rx[32*rb_idx_q[IDX_W-1:0] +: 32] : arg_q;
      3'd1: reg_rdata = {12'b0, bsy_q, lvar_q, 1'b0, nocrc_q, rlen_q, cmdb_q};
      3'd2: begin
        reg_rdata[DIV_W-1:0]   = div_q;
        reg_rdata[12 +: ABITS_W] = abits_q;
        reg_rdata[24 +: TMO_W]   = tmo_q;
      end
      3'd3: begin
        reg_rdata[0]  = active;
        reg_rdata[5]  = ok_q;
        reg_rdata[9]  = st_done;
        reg_rdata[10] = to_q;
      end
      3'd4: reg_rdata[4] = ien_q;
      3'd5: reg_rdata = {16'b0, rb_idx_q, 3'b0, rb_en_q, 6'b0, port_q};
      default: reg_rdata = '0;
    endcase
  end

  logic unused_bits;
  assign unused_bits = &{1'b0, reg_wdata[31:20], reg_wdata[17], reg_wdata[11:10], rb_idx_q[3:IDX_W]};
endmodule

// File: rtl/sd_cmd_engine_chk.sv
`timescale 1ns/1ps
module sd_cmd_engine_chk (
  input logic clk,
  input logic rst_n,
  input logic cmd_o,
  input logic sd_clk,
  input logic active,
  input logic st_done,
  input logic to_q,
  input logic soft_rst,
  input logic busy_st,
  input logic wait_st,
  input logic dat0_i
);
  // R3
  idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> cmd_o);
  // R3
  cmd_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cmd_o) |-> ($fell(sd_clk) || $past(soft_rst)));
  // R8
  done_after_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_done) |-> $past(active));
  // R7
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_st && !dat0_i && !soft_rst) |=> busy_st);
  // R10
  timeout_from_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(to_q) |-> $past(wait_st));
  // R12
  soft_reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !active);
endmodule

bind sd_cmd_engine sd_cmd_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_o(cmd_o), .sd_clk(sd_clk), .active(active),
  .st_done(st_done), .to_q(to_q), .soft_rst(soft_rst), .busy_st(busy_st),
  .wait_st(wait_st), .dat0_i(dat0_i));

// File: tb/tb_sd_cmd_engine.sv
`timescale 1ns/1ps
module tb_sd_cmd_engine;
  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [2:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic sd_clk, cmd_o, cmd_i = 1, dat0_i = 1, irq;
  logic [1:0] port_sel;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  sd_cmd_engine dut (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sd_clk(sd_clk),
    .cmd_o(cmd_o), .cmd_i(cmd_i), .dat0_i(dat0_i), .port_sel(port_sel), .irq(irq));

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  function automatic logic [6:0] crc_vec(input logic [135:0] v, input int hi, input int lo);
    logic [6:0] c = 0;
    logic fb;
    for (int i = hi; i >= lo; i--) begin
      fb = v[i] ^ c[6];
      c = {c[5:0], 1'b0} ^ {3'b000, fb, 2'b00, fb};
    end
    return c;
  endfunction

  function automatic logic [47:0] frame_of(input logic [7:0] c, input logic [31:0] a);
    logic [135:0] v = {96'b0, c, a};
    return {c, a, crc_vec(v, 39, 0), 1'b1};
  endfunction

  task automatic grab(output logic [47:0] f);
    @(negedge cmd_o);
    for (int i = 47; i >= 0; i--) begin
      @(posedge sd_clk); #1 f[i] = cmd_o;
    end
  endtask

  task automatic respond(input logic [135:0] b, input int n);
    @(negedge sd_clk); #1 cmd_i = 1;
    @(negedge sd_clk); #1 cmd_i = 1;
    @(negedge sd_clk); #1 cmd_i = 0;
    for (int i = n; i >= 0; i--) begin
      @(negedge sd_clk); #1 cmd_i = b[i];
    end
    @(negedge sd_clk); #1 cmd_i = 1;
  endtask

  task automatic wait_done(output logic [31:0] s);
    for (int i = 0; i < 4000; i++) begin
      rd(3'd3, s);
      if (s[9]) break;
    end
  endtask

  initial begin
    #1_500_000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, s, arg, sendw;
    logic [47:0] f;
    logic [135:0] b;
    logic [7:0] cb;
    realtime t0;
    bit longr, bad;
    int seedv;
    seedv = $urandom(32'd1357);

    repeat (3) @(negedge clk);
    #1;
    chk(cmd_o === 1'b1 && sd_clk === 1'b0, "R1 lines", {cmd_o, sd_clk}, 2'b10);
    rst_n = 1;
    rd(3'd2, d); chk(d == 32'h4002_71F4, "R1 cfg", d, 32'h4002_71F4);
    rd(3'd3, d); chk(d == 0, "R1 stat", d, 0);

    @(posedge sd_clk); t0 = $realtime; @(posedge sd_clk);
    chk($realtime - t0 == 10020.0, "R2 reset period", int'($realtime - t0), 10020);
    wr(3'd2, 32'h4002_7003);
    @(posedge sd_clk); @(posedge sd_clk); t0 = $realtime; @(posedge sd_clk);
    chk($realtime - t0 == 80.0, "R2 div3 period", int'($realtime - t0), 80);
    wr(3'd2, 32'h4002_7001);

    wr(3'd5, 32'h2); #1;
    chk(port_sel == 2'd2, "R13 port", port_sel, 2);

    // R4: no response
    arg = 32'hA5C3_0F1E; cb = 8'h40 | 8'd0;
    wr(3'd0, arg); wr(3'd1, {24'b0, cb});
    grab(f); chk(f == frame_of(cb, arg), "R3 frame", f, frame_of(cb, arg));
    wait_done(s); chk(s[9] && !s[0] && !s[10], "R4 no-resp done", s, 32'h200);
    wr(3'd3, 32'h620);

    // R11: send write while active ignored
    arg = 32'h1234_5678; cb = 8'h40 | 8'd13; sendw = {24'b0, cb};
    wr(3'd0, arg); wr(3'd1, sendw);
    fork
      grab(f);
      begin repeat (4) @(posedge sd_clk); wr(3'd1, 32'h0008_2D77); end
    join
    chk(f == frame_of(cb, arg), "R11 frame kept", f, frame_of(cb, arg));
    rd(3'd1, d); chk(d == sendw, "R11 send kept", d, sendw);
    wait_done(s); wr(3'd3, 32'h620);

    // R7: busy hold
    dat0_i = 0; cb = 8'h40 | 8'd7;
    wr(3'd1, {12'h000, 4'h8, 8'd0, cb});
    grab(f);
    repeat (20) @(posedge sd_clk);
    rd(3'd3, s); chk(s[0] && !s[9], "R7 held busy", s, 1);
    dat0_i = 1;
    wait_done(s); chk(s[9] && !s[0], "R7 released", s, 32'h200);
    wr(3'd3, 32'h620);

    // R10: timeout
    wr(3'd2, 32'h0502_7001);
    cb = 8'h40 | 8'd2; wr(3'd1, {16'b0, 8'd45, cb});
    grab(f); wait_done(s);
    chk(s[10] && s[9] && !s[5], "R10 timeout", s, 32'h600);
    wr(3'd3, 32'h620); rd(3'd3, s); chk(s == 0, "R8 w1c", s, 0);
    wr(3'd2, 32'h4002_7001);

    // R12: soft reset mid frame
    cb = 8'h40 | 8'd9; wr(3'd1, {16'b0, 8'd45, cb});
    @(negedge cmd_o); repeat (5) @(posedge sd_clk);
    wr(3'd4, 32'h8000); #1;
    chk(cmd_o === 1'b1, "R12 line high", cmd_o, 1);
    rd(3'd3, s); chk(s == 0, "R12 stat clear", s, 0);
    rd(3'd4, d); chk(d[15] == 0, "R12 self clear", d, 0);

    // R5 skip: bad crc with skip bit
    b = '0; b[44:39] = 6'd17; b[38:7] = 32'hDEAD_BEEF;
    b[6:0] = crc_vec(b, 45, 7) ^ 7'h01;
    cb = 8'h40 | 8'd17; wr(3'd1, {15'b0, 1'b1, 8'd45, cb});
    grab(f); respond(b, 45); wait_done(s);
    chk(s[9] && !s[5], "R5 skip", s, 32'h200);
    wr(3'd3, 32'h620);

    wr(3'd4, 32'h10);
    for (int it = 0; it < 18; it++) begin
      longr = ($urandom % 3) == 0;
      bad   = ($urandom % 4) == 0;
      arg = $urandom; cb = 8'h40 | 8'($urandom % 64);
      b = '0;
      if (longr) begin
        b[132:127] = 6'h3f;
        b[126:7] = {$urandom, $urandom, $urandom, $urandom} >> 8;
        b[6:0] = crc_vec(b, 126, 7);
        sendw = {13'b0, 1'b1, 2'b0, 8'd133, cb};
      end else begin
        b[44:39] = cb[5:0]; b[38:7] = $urandom;
        b[6:0] = crc_vec(b, 45, 7);
        sendw = {16'b0, 8'd45, cb};
      end
      if (bad) b[3] = ~b[3];
      wr(3'd0, arg); wr(3'd1, sendw);
      grab(f); chk(f == frame_of(cb, arg), "R3 frame rnd", f, frame_of(cb, arg));
      respond(b, longr ? 133 : 45);
      wait_done(s);
      chk(s[9] && !s[10], "R4 done", s, 32'h200);
      chk(s[5] == !bad, longr ? "R6 long crc" : "R5 short crc", s[5], !bad);
      @(negedge clk); #1 chk(irq === 1'b1, "R8 irq", irq, 1);
      wr(3'd5, 32'h102);
      for (int w = 0; w < 4; w++) begin
        rd(3'd0, d);
        chk(d == b[32*w +: 32], "R9 readback", d, b[32*w +: 32]);
      end
      rd(3'd5, d); chk(d[15:12] == 4, "R9 index", d[15:12], 4);
      wr(3'd5, 32'h2);
      rd(3'd0, d); chk(d == arg, "R9 arg view", d, arg);
      wr(3'd3, 32'h620); #1;
      chk(irq === 1'b0, "R8 irq clear", irq, 0);
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule